// File: doc/BRIEF.md
# Multi-Mode Buffered Serial Port

This block is a byte-oriented serial port with four framings chosen by a 2-bit mode input. Mode 0 is a clocked shift mode: the block drives a shift clock and moves 8 bits over a single data line, either out or in, one direction at a time. Modes 1, 2 and 3 are asynchronous frames on separate receive and transmit lines, and receive and transmit run at the same time. Every serial bit lasts 16 ticks. In modes 0, 1 and 3 the tick is the `baud_tick` input. In mode 2 it is an internal tick, one every `FIX_DIV` clocks.

The host side uses two streams. The transmit stream (`tx_valid`/`tx_ready`/`tx_data`) writes into a one-entry holding register. `tx_ready` is high only while that register is empty. A byte is taken on a clock edge where both `tx_valid` and `tx_ready` are high. While `tx_ready` is low the host must hold `tx_valid` and `tx_data` steady. The holding register hands its byte to the shifter when the shifter frees up, so the host can load the next byte while the current one is still going out.

The receive stream (`rx_valid`/`rx_ready`/`rx_data`) presents a one-entry holding register. The byte stays there until a cycle with `rx_ready` high. The serial line cannot be stalled. A frame that completes while the holding register is still full is dropped and raises `overrun`.

Top module: `serial_port_mm`

## Requirements
- R1: After reset, `tx_ready`=1, `tx_empty`=1, `rx_valid`=0, `overrun`=0, `txd_o`=1, `sclk_o`=1 and `line_oe`=0.
- R2: Each bit lasts 16 ticks. Modes 1 and 3 count `baud_tick` pulses. Mode 2 counts an internal tick that fires every `FIX_DIV` clocks and ignores `baud_tick`. Mode 1 carries 8 data bits; modes 2 and 3 carry 9 (`tx_data[8]`/`rx_data[8]` is the ninth bit).
- R3: An asynchronous transmit frame on `txd_o` is a 0 start bit, then the data bits LSB first, then a 1 stop bit. The idle line is 1.
- R4: When the holding register moves to the shifter, `tx_irq` pulses for one cycle and `tx_ready` goes high. If a byte is waiting when a frame's stop bit ends, the next start bit follows at once, with no extra idle bit.
- R5: While the holding register is full, `tx_ready` stays 0 and a presented byte is not taken. Once space frees up it is taken and sent in order, with nothing lost.
- R6: The asynchronous receiver samples each bit 16 ticks after the previous sample, starting at mid-start-bit. On the cycle after a frame completes, `rx_irq` pulses with `rx_valid`=1. In mode 1, `rx_data[8]`=0.
- R7: A low pulse on `line_i` shorter than half a bit, which is high again at the mid-start check, is discarded and delivers nothing.
- R8: A second frame can arrive while the first is unread. If the host reads the first before the second completes, both are delivered in order with no overrun.
- R9: If a frame completes while `rx_valid`=1 and `rx_ready`=0, `overrun` goes to 1 and the older byte stays in `rx_data`. A read of that byte clears `overrun`.
- R10: In asynchronous modes a transmit frame and a receive frame can be in flight at the same time, and both are correct.
- R11: A mode 0 transmit drives the 8 bits LSB first on `line_o` with `line_oe`=1. Each bit has `sclk_o` low for its first half and high for its second half. `line_o` is stable at each rising edge of `sclk_o`, and `txd_o` stays 1.
- R12: In mode 0, a `sync_rx_go` pulse while the transmitter is idle and empty starts an 8-bit receive. The block toggles `sclk_o` and samples `line_i` at the end of each high phase, LSB first. The result is delivered like an asynchronous byte. A `sync_rx_go` pulse while the transmitter holds or sends a byte is ignored. `line_oe` and a receive in progress never overlap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode | input | 2 | Framing select, 0..3 |
| baud_tick | input | 1 | Oversampling tick for modes 0, 1, 3 |
| tx_valid | input | 1 | Transmit byte offered |
| tx_ready | output | 1 | Transmit holding register empty |
| tx_data | input | 9 | Transmit byte, bit 8 used in modes 2 and 3 |
| rx_valid | output | 1 | Received byte held |
| rx_ready | input | 1 | Host takes the held byte |
| rx_data | output | 9 | Received byte |
| sync_rx_go | input | 1 | Starts a mode 0 receive |
| line_i | input | 1 | Data line input (async receive, mode 0 receive) |
| line_o | output | 1 | Data line drive value in mode 0 |
| line_oe | output | 1 | Data line drive enable in mode 0 |
| txd_o | output | 1 | Asynchronous transmit line |
| sclk_o | output | 1 | Mode 0 shift clock, idle high |
| tx_empty | output | 1 | Holding register and shifter both empty |
| tx_irq | output | 1 | Pulse: holding register moved to shifter |
| rx_irq | output | 1 | Pulse: frame fully received |
| overrun | output | 1 | Frame lost because the held byte was unread |

## Verification
A wrong bit counter or tick selection shows on `txd_o` within one frame: the mid-bit samples of a line monitor misread a bit or the stop bit, and a wrong divide in mode 2 shows up by the second data bit. A receive state that lingers or aborts early shows as a wrong `rx_data` or a missing `rx_valid` within one frame time. A holding register that loses or duplicates a byte shows as an out-of-order transmit byte or a wrong `overrun` level at the next read. Mode 0 faults in the shift clock phase show at the first rising edge of `sclk_o`, because the monitor samples `line_o` there.

// File: rtl/spmm_pkg.sv
package spmm_pkg;
  typedef enum logic [1:0] {
    MODE_SYNC   = 2'd0,
    MODE_A8     = 2'd1,
    MODE_A9_FIX = 2'd2,
    MODE_A9_BR  = 2'd3
  } spmm_mode_e;

  typedef enum logic [2:0] {
    RS_IDLE  = 3'd0,
    RS_START = 3'd1,
    RS_DATA  = 3'd2,
    RS_STOP  = 3'd3,
    RS_SYNC  = 3'd4
  } spmm_rx_state_e;
endpackage

// File: rtl/spmm_tick.sv
module spmm_tick #(
  parameter int FIX_DIV = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] mode,
  input  logic       baud_tick,
  output logic       tick
);
  import spmm_pkg::*;
  logic fix_pulse;

  generate
    if (FIX_DIV <= 1) begin : g_nodiv
      assign fix_pulse = 1'b1;
    end else begin : g_div
      localparam int DCW = $clog2(FIX_DIV);
      logic [DCW-1:0] dcnt;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) dcnt <= '0;
        else if (dcnt == DCW'(FIX_DIV - 1)) dcnt <= '0;
        else dcnt <= dcnt + 1'b1;
      end
      assign fix_pulse = (dcnt == DCW'(FIX_DIV - 1));
    end
  endgenerate

  assign tick = (spmm_mode_e'(mode) == MODE_A9_FIX) ? fix_pulse : baud_tick;
endmodule

// File: rtl/spmm_tx.sv
module spmm_tx #(
  parameter int OSR = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] mode,
  input  logic       tick,
  input  logic       in_valid,
  output logic       in_ready,
  input  logic [8:0] in_data,
  input  logic       peer_busy,
  output logic       txd,
  output logic       sd_o,
  output logic       sd_oe,
  output logic       sclk,
  output logic       irq,
  output logic       active
);
  import spmm_pkg::*;
  localparam int CW   = $clog2(OSR);
  localparam int HALF = OSR / 2;

  logic          hold_v;
  logic [8:0]    hold_d;
  logic          busy;
  logic          sync_frame;
  logic [10:0]   sh;
  logic [3:0]    left;
  logic [CW-1:0] tcnt;
  logic          bit_end, last_bit, load, accept;

  assign in_ready = !hold_v;
  assign accept   = in_valid && !hold_v;
  assign bit_end  = busy && tick && (tcnt == CW'(OSR - 1));
  assign last_bit = bit_end && (left == 4'd1);
  assign load     = hold_v && (!busy || last_bit) && !peer_busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_v <= 1'b0;
      hold_d <= '0;
    end else if (accept) begin
      hold_v <= 1'b1;
      hold_d <= in_data;
    end else if (load) begin
      hold_v <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy       <= 1'b0;
      sync_frame <= 1'b0;
      sh         <= '1;
      left       <= '0;
      tcnt       <= '0;
      irq        <= 1'b0;
    end else begin
      irq <= load;
      if (load) begin
        busy <= 1'b1;
        tcnt <= '0;
        sync_frame <= (spmm_mode_e'(mode) == MODE_SYNC);
        case (spmm_mode_e'(mode))
          MODE_SYNC: begin sh <= {3'b111, hold_d[7:0]};        left <= 4'd8;  end
          MODE_A8:   begin sh <= {2'b11, hold_d[7:0], 1'b0};   left <= 4'd10; end
          default:   begin sh <= {1'b1, hold_d, 1'b0};         left <= 4'd11; end
        endcase
      end else if (bit_end) begin
        tcnt <= '0;
        sh   <= {1'b1, sh[10:1]};
        left <= left - 4'd1;
        if (left == 4'd1) busy <= 1'b0;
      end else if (busy && tick) begin
        tcnt <= tcnt + 1'b1;
      end
    end
  end

  assign txd    = (busy && !sync_frame) ? sh[0] : 1'b1;
  assign sd_o   = sh[0];
  assign sd_oe  = busy && sync_frame;
  assign sclk   = sd_oe ? (tcnt >= CW'(HALF)) : 1'b1;
  assign active = busy || hold_v;

  // R4: a move into the shifter leaves the holding register free
  assert_irq_frees_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> in_ready);
  // R5: a waiting byte is never altered before it is sent
  assert_hold_kept_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_v && !load) |=> (hold_v && $stable(hold_d)));
  // R11: async line quiet while the shift mode drives the data line
  assert_sync_txd_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    sd_oe |-> txd);
  // R11: data stable across the rising shift clock
  assert_sync_data_stable_R11: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(sclk) && sd_oe) |-> $stable(sd_o));
endmodule

// File: rtl/spmm_rx.sv
module spmm_rx #(
  parameter int OSR = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] mode,
  input  logic       tick,
  input  logic       line_i,
  input  logic       sync_go,
  input  logic       tx_active,
  output logic       out_valid,
  input  logic       out_ready,
  output logic [8:0] out_data,
  output logic       overrun,
  output logic       irq,
  output logic       sync_busy,
  output logic       sclk
);
  import spmm_pkg::*;
  localparam int CW   = $clog2(OSR);
  localparam int HALF = OSR / 2;

  spmm_rx_state_e st;
  logic          s1, s2;
  logic [CW-1:0] cnt;
  logic [3:0]    nleft;
  logic [8:0]    rsh;
  logic          nine;
  logic          frame_done;
  logic [8:0]    nd;
  logic          take;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= 1'b1;
      s2 <= 1'b1;
    end else begin
      s1 <= line_i;
      s2 <= s1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= RS_IDLE;
      cnt <= '0;
      nleft <= '0;
      rsh <= '0;
      nine <= 1'b0;
      frame_done <= 1'b0;
    end else begin
      frame_done <= 1'b0;
      case (st)
        RS_IDLE: begin
          cnt <= '0;
          if (spmm_mode_e'(mode) == MODE_SYNC) begin
            if (sync_go && !tx_active) begin
              st <= RS_SYNC;
              nleft <= 4'd8;
              nine <= 1'b0;
            end
          end else if (tick && !s2) begin
            st <= RS_START;
            nine <= (spmm_mode_e'(mode) != MODE_A8);
            nleft <= (spmm_mode_e'(mode) == MODE_A8) ? 4'd8 : 4'd9;
          end
        end
        RS_START: if (tick) begin
          if (cnt == CW'(HALF - 1)) begin
            cnt <= '0;
            st <= s2 ? RS_IDLE : RS_DATA;
          end else cnt <= cnt + 1'b1;
        end
        RS_DATA: if (tick) begin
          if (cnt == CW'(OSR - 1)) begin
            cnt <= '0;
            rsh <= {s2, rsh[8:1]};
            nleft <= nleft - 4'd1;
            if (nleft == 4'd1) st <= RS_STOP;
          end else cnt <= cnt + 1'b1;
        end
        RS_STOP: if (tick) begin
          if (cnt == CW'(OSR - 1)) begin
            cnt <= '0;
            st <= RS_IDLE;
            frame_done <= 1'b1;
          end else cnt <= cnt + 1'b1;
        end
        RS_SYNC: if (tick) begin
          if (cnt == CW'(OSR - 1)) begin
            cnt <= '0;
            rsh <= {s2, rsh[8:1]};
            nleft <= nleft - 4'd1;
            if (nleft == 4'd1) begin
              st <= RS_IDLE;
              frame_done <= 1'b1;
            end
          end else cnt <= cnt + 1'b1;
        end
        default: st <= RS_IDLE;
      endcase
    end
  end

  assign nd   = nine ? rsh : {1'b0, rsh[8:1]};
  assign take = out_valid && out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      overrun   <= 1'b0;
      irq       <= 1'b0;
    end else begin
      irq <= frame_done;
      if (take) begin
        out_valid <= 1'b0;
        overrun   <= 1'b0;
      end
      if (frame_done) begin
        if (out_valid && !out_ready) overrun <= 1'b1;
        else begin
          out_valid <= 1'b1;
          out_data  <= nd;
        end
      end
    end
  end

  assign sync_busy = (st == RS_SYNC);
  assign sclk      = sync_busy ? (cnt >= CW'(HALF)) : 1'b1;

  // R6: completion pulse always comes with a held byte
  assert_irq_has_data_R6: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> out_valid);
  // R9: an unread byte is neither dropped nor overwritten
  assert_held_byte_kept_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));
  // R9: overrun only rises while a byte was held
  assert_overrun_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(overrun) |-> $past(out_valid));
endmodule

// File: rtl/serial_port_mm.sv
module serial_port_mm #(
  parameter int OSR     = 16,
  parameter int FIX_DIV = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] mode,
  input  logic       baud_tick,
  input  logic       tx_valid,
  output logic       tx_ready,
  input  logic [8:0] tx_data,
  output logic       rx_valid,
  input  logic       rx_ready,
  output logic [8:0] rx_data,
  input  logic       sync_rx_go,
  input  logic       line_i,
  output logic       line_o,
  output logic       line_oe,
  output logic       txd_o,
  output logic       sclk_o,
  output logic       tx_empty,
  output logic       tx_irq,
  output logic       rx_irq,
  output logic       overrun
);
  logic tick, tx_active, rx_sync_busy, sclk_tx, sclk_rx;

  spmm_tick #(.FIX_DIV(FIX_DIV)) u_tick (
    .clk(clk), .rst_n(rst_n), .mode(mode), .baud_tick(baud_tick), .tick(tick)
  );

  spmm_tx #(.OSR(OSR)) u_tx (
    .clk(clk), .rst_n(rst_n), .mode(mode), .tick(tick),
    .in_valid(tx_valid), .in_ready(tx_ready), .in_data(tx_data),
    .peer_busy(rx_sync_busy), .txd(txd_o), .sd_o(line_o), .sd_oe(line_oe),
    .sclk(sclk_tx), .irq(tx_irq), .active(tx_active)
  );

  spmm_rx #(.OSR(OSR)) u_rx (
    .clk(clk), .rst_n(rst_n), .mode(mode), .tick(tick), .line_i(line_i),
    .sync_go(sync_rx_go), .tx_active(tx_active),
    .out_valid(rx_valid), .out_ready(rx_ready), .out_data(rx_data),
    .overrun(overrun), .irq(rx_irq), .sync_busy(rx_sync_busy), .sclk(sclk_rx)
  );

  assign sclk_o   = sclk_tx & sclk_rx;
  assign tx_empty = !tx_active;

  // R12: shift-mode transmit and receive never overlap
  assert_half_duplex_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !(line_oe && rx_sync_busy));
  // R11: shift clock idles high when no shift transfer runs
  assert_sclk_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!line_oe && !rx_sync_busy) |-> sclk_o);
endmodule

// File: tb/serial_port_mm_test.sv
module serial_port_mm_test;
  localparam int TDIV = 4;
  localparam int FIXD = 8;
  localparam int BT13 = 16 * TDIV;
  localparam int BT2  = 16 * FIXD;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [1:0] mode = 2'd1;
  logic baud_tick = 1'b0, tx_valid = 1'b0, rx_ready = 1'b0, sync_rx_go = 1'b0, line_i = 1'b1;
  logic [8:0] tx_data = '0;
  logic tx_ready, rx_valid, line_o, line_oe, txd_o, sclk_o, tx_empty, tx_irq, rx_irq, overrun;
  logic [8:0] rx_data;

  int checks = 0, failures = 0, tx_irq_n = 0, rx_irq_n = 0, bcnt = 0, idle_cnt = 0;
  bit gap_armed = 0;
  logic [8:0] txq[$];

  serial_port_mm #(.OSR(16), .FIX_DIV(FIXD)) uut (
    .clk(clk), .rst_n(rst_n), .mode(mode), .baud_tick(baud_tick),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data),
    .sync_rx_go(sync_rx_go), .line_i(line_i), .line_o(line_o), .line_oe(line_oe),
    .txd_o(txd_o), .sclk_o(sclk_o), .tx_empty(tx_empty), .tx_irq(tx_irq),
    .rx_irq(rx_irq), .overrun(overrun)
  );

  always #4 clk = ~clk;

  always @(negedge clk) begin
    bcnt <= (bcnt == TDIV - 1) ? 0 : bcnt + 1;
    baud_tick <= (bcnt == TDIV - 1);
    if (rst_n && tx_irq) tx_irq_n <= tx_irq_n + 1;
    if (rst_n && rx_irq) rx_irq_n <= rx_irq_n + 1;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int bt_of(input logic [1:0] m);
    return (m == 2'd2) ? BT2 : BT13;
  endfunction

  // async transmit line monitor (R2, R3, R4)
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && mode != 2'd0 && txd_o === 1'b0) begin
        automatic logic [1:0] m = mode;
        automatic int bt = bt_of(m);
        automatic int nb = (m == 2'd1) ? 8 : 9;
        automatic logic [8:0] v = '0;
        automatic logic [8:0] e = '0;
        if (gap_armed) chk(idle_cnt <= bt / 2 + 4, "R4 no idle gap", idle_cnt, bt / 2);
        repeat (bt / 2) @(negedge clk);
        chk(txd_o == 1'b0, "R3 start bit", txd_o, 0);
        for (int k = 0; k < nb; k++) begin
          repeat (bt) @(negedge clk);
          v[k] = txd_o;
        end
        repeat (bt) @(negedge clk);
        chk(txd_o == 1'b1, "R3 stop bit", txd_o, 1);
        if (txq.size() > 0) e = txq.pop_front();
        if (m == 2'd1) e[8] = 1'b0;
        chk(v == e, "R2/R3 tx frame data", v, e);
        idle_cnt = 0;
      end else if (txd_o === 1'b1) begin
        idle_cnt++;
      end
    end
  end

  // shift-mode transmit monitor (R11)
  initial begin
    automatic int nbit = 0;
    automatic logic [7:0] v = '0;
    forever begin
      @(posedge sclk_o);
      if (rst_n && line_oe) begin
        v[nbit] = line_o;
        chk(txd_o == 1'b1, "R11 txd quiet", txd_o, 1);
        nbit++;
        if (nbit == 8) begin
          automatic logic [8:0] e = (txq.size() > 0) ? txq.pop_front() : 9'h0;
          chk(v == e[7:0], "R11 shift tx data", v, e[7:0]);
          nbit = 0;
        end
      end
    end
  end

  task automatic put_tx(input logic [8:0] d);
    txq.push_back(d);
    @(negedge clk);
    tx_valid = 1'b1;
    tx_data = d;
    while (!tx_ready) @(negedge clk);
    @(negedge clk);
    tx_valid = 1'b0;
  endtask

  task automatic wait_tx_done();
    int t = 0;
    while ((txq.size() != 0 || !tx_empty) && t < 20000) begin
      @(negedge clk);
      t++;
    end
    repeat (bt_of(mode)) @(negedge clk);
  endtask

  task automatic drive_frame(input logic [1:0] m, input logic [8:0] d);
    int bt = bt_of(m);
    int nb = (m == 2'd1) ? 8 : 9;
    line_i = 1'b0;
    repeat (bt) @(negedge clk);
    for (int k = 0; k < nb; k++) begin
      line_i = d[k];
      repeat (bt) @(negedge clk);
    end
    line_i = 1'b1;
    repeat (bt) @(negedge clk);
  endtask

  task automatic get_rx(input logic [8:0] exp, input string req);
    int t = 0;
    while (!rx_valid && t < 5000) begin
      @(negedge clk);
      t++;
    end
    chk(rx_valid == 1'b1, req, rx_valid, 1);
    chk(rx_data == exp, req, rx_data, exp);
    rx_ready = 1'b1;
    @(negedge clk);
    rx_ready = 1'b0;
  endtask

  task automatic finish_up();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_up();
  end

  initial begin
    int irq0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(tx_ready && tx_empty, "R1 tx idle", {tx_ready, tx_empty}, 3);
    chk(!rx_valid && !overrun, "R1 rx idle", {rx_valid, overrun}, 0);
    chk(txd_o && sclk_o && !line_oe, "R1 lines", {txd_o, sclk_o, line_oe}, 6);

    // R2 R3 mode 1 single byte
    mode = 2'd1;
    put_tx(9'h0A5);
    wait_tx_done();

    // R4 R5 streaming with back-pressure
    irq0 = tx_irq_n;
    put_tx(9'h011);
    put_tx(9'h0E7);
    gap_armed = 1;
    txq.push_back(9'h03C);
    @(negedge clk);
    tx_valid = 1'b1;
    tx_data = 9'h03C;
    repeat (5) @(negedge clk);
    chk(tx_ready == 1'b0, "R5 back-pressure", tx_ready, 0);
    while (!tx_ready) @(negedge clk);
    @(negedge clk);
    tx_valid = 1'b0;
    wait_tx_done();
    gap_armed = 0;
    chk(tx_irq_n - irq0 == 3, "R4 tx_irq count", tx_irq_n - irq0, 3);

    // R2 modes 3 and 2, nine bits
    mode = 2'd3;
    put_tx(9'h1C3);
    put_tx(9'h03C);
    wait_tx_done();
    mode = 2'd2;
    put_tx(9'h155);
    wait_tx_done();

    // R6 receive mode 1
    mode = 2'd1;
    irq0 = rx_irq_n;
    drive_frame(2'd1, 9'h03C);
    get_rx(9'h03C, "R6 rx mode1");
    chk(rx_irq_n - irq0 == 1, "R6 rx_irq", rx_irq_n - irq0, 1);

    // R7 false start
    line_i = 1'b0;
    repeat (12) @(negedge clk);
    line_i = 1'b1;
    repeat (300) @(negedge clk);
    chk(rx_valid == 1'b0, "R7 false start", rx_valid, 0);
    drive_frame(2'd1, 9'h081);
    get_rx(9'h081, "R7 after false start");

    // R8 double buffer
    drive_frame(2'd1, 9'h0A1);
    fork
      drive_frame(2'd1, 9'h0B2);
      begin repeat (300) @(negedge clk); get_rx(9'h0A1, "R8 first"); end
    join
    get_rx(9'h0B2, "R8 second");
    chk(overrun == 1'b0, "R8 no overrun", overrun, 0);

    // R9 overrun
    drive_frame(2'd1, 9'h0C3);
    drive_frame(2'd1, 9'h0D4);
    chk(overrun == 1'b1, "R9 overrun set", overrun, 1);
    get_rx(9'h0C3, "R9 older kept");
    chk(overrun == 1'b0 && rx_valid == 1'b0, "R9 cleared on read", {overrun, rx_valid}, 0);

    // R2 R6 nine-bit receive modes 3 and 2
    mode = 2'd3;
    drive_frame(2'd3, 9'h1A5);
    get_rx(9'h1A5, "R6 rx mode3");
    mode = 2'd2;
    drive_frame(2'd2, 9'h14B);
    get_rx(9'h14B, "R2 rx mode2");

    // R10 full duplex
    mode = 2'd1;
    fork
      put_tx(9'h05A);
      drive_frame(2'd1, 9'h0C6);
    join
    wait_tx_done();
    get_rx(9'h0C6, "R10 rx during tx");

    // R11 shift-mode transmit
    mode = 2'd0;
    repeat (10) @(negedge clk);
    put_tx(9'h096);
    wait_tx_done();

    // R12 shift-mode receive
    fork
      for (int k = 0; k < 8; k++) begin
        @(negedge sclk_o);
        line_i = 8'h6D >> k;
      end
      begin
        @(negedge clk);
        sync_rx_go = 1'b1;
        @(negedge clk);
        sync_rx_go = 1'b0;
      end
    join
    repeat (BT13) @(negedge clk);
    line_i = 1'b1;
    get_rx(9'h06D, "R12 shift rx");

    // R12 go ignored while transmitter busy
    put_tx(9'h00F);
    repeat (20) @(negedge clk);
    sync_rx_go = 1'b1;
    @(negedge clk);
    sync_rx_go = 1'b0;
    wait_tx_done();
    repeat (10 * BT13) @(negedge clk);
    chk(rx_valid == 1'b0, "R12 go ignored", rx_valid, 0);

    finish_up();
  end
endmodule